// File: doc/BRIEF.md
# Matrix Keypad Scan Controller

The controller walks a switch matrix of up to 16 rows and 8 columns. It drives one row at a time and reads the column lines back. Every timing figure is a count of scan clock cycles, and the scan clock is nominally 32 kHz. After a short lead-in, each row gets a slot of 16 settle cycles followed by a debounce window whose length software programs. A column is accepted as pressed only if it holds steady across that whole window.

Pressed keys are collected during each pass. When the last row of the pass finishes, they are published as a snapshot of at most eight byte-sized entries, together with a count. Software reads the snapshot through a small word-addressed register port. The same port gives access to control, interrupt status and per-row wake masks. The block can raise two interrupts: one for a key in an unmasked row, and one for the entry count reaching a programmed threshold. Both latch until software writes a one to clear them.

Top module: `keypad_scan_ctrl`

## Requirements
- R1: After reset, every register reads zero, no row is driven and irq is low. The word addresses are: 0 control, 1 status, 2 entries 0..3, 3 entries 4..7, 4 row mask.
- R2: Control bit 0 enables the block, and bits 13:4 hold the debounce count D. Once enabled, rows stay idle for 5 cycles. Each row is then driven, one-hot and in ascending order, for 16+D cycles, and after the last row the pass starts over.
- R3: A column counts as pressed only when it reads 1 at the end of its row slot and matched its value at slot cycle 15 on every one of the D cycles after that. A column that toggles inside the window is never entered.
- R4: An entry byte holds valid in bit 7, the row in bits 6:3 and the column in bits 2:0. Entries are ordered by row ascending, then column ascending. Status bits 7:4 give the entry count, and the snapshot is replaced at the end of every pass.
- R5: Entries 0..3 occupy address 2 and entries 4..7 occupy address 3, with the lowest index in the least-significant byte. Unused bytes read as zero. Keys beyond the eighth in a pass are dropped and the count stays at 8.
- R6: Status bit 0 (keypress) is set at the end of a pass in which some unmasked row had an accepted key, provided control bit 1 was set.
- R7: Bit r of the row-mask register stops row r from setting status bit 0. Keys in a masked row are still listed in the entries.
- R8: Status bit 2 (count) is set at the end of a pass when control bit 3 is set and the entry count is at least the threshold held in control bits 17:14.
- R9: Writing a one to a status interrupt bit clears it, and zero bits leave it unchanged. irq is the OR of the two status interrupt bits.
- R10: With control bit 0 clear, no row is driven, the entries and the count read zero, both interrupt bits clear and irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Word address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| row_drive | output | N_ROWS | Row drive, active high, at most one set |
| col_sense | input | N_COLS | Column readback, 1 = contact closed |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a column that bounces inside the debounce window yet happens to read 1 on the final sample, because a static key map can never produce it. The bench models the matrix as combinational logic driven by row_drive. For one key it can switch in a contact that flips on every clock, so the value sampled at each edge alternates during every window. With a debounce count of 8, that key must stay absent from the snapshot, while the same key held steady is accepted.

// File: rtl/kps_pkg.sv
package kps_pkg;
   localparam int ENT_W       = 8;
   localparam int ROW_FLD_W   = 4;
   localparam int COL_FLD_W   = 3;
   localparam int DB_W        = 10;
   localparam int THR_W       = 4;
   localparam int PRE_CYC     = 5;
   localparam int SETTLE_CYC  = 16;
   localparam int MAX_ROWS    = 16;
   localparam int MAX_COLS    = 8;
   localparam int MAX_ENT     = 8;

   localparam int CTL_EN      = 0;
   localparam int CTL_KPIE    = 1;
   localparam int CTL_CNTIE   = 3;
   localparam int CTL_DB_LSB  = 4;
   localparam int CTL_THR_LSB = 14;
   localparam int ST_KP       = 0;
   localparam int ST_CNT      = 2;
   localparam int ST_NUM_LSB  = 4;

   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_STAT   = 3'd1;
   localparam logic [2:0] A_ENT_LO = 3'd2;
   localparam logic [2:0] A_ENT_HI = 3'd3;
   localparam logic [2:0] A_MASK   = 3'd4;

   typedef struct packed {
      logic                 valid;
      logic [ROW_FLD_W-1:0] row;
      logic [COL_FLD_W-1:0] col;
   } key_ent_t;
endpackage

// File: rtl/kps_sequencer.sv
module kps_sequencer
   import kps_pkg::*;
#(
   parameter int N_ROWS = 16,
   localparam int RW = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DB_W-1:0]   dbc,
   output logic [N_ROWS-1:0] row_drive,
   output logic [RW-1:0]     row_sel,
   output logic              ref_stb,
   output logic              last_stb,
   output logic              pass_end
);
   localparam int CW = DB_W + 2;

   logic          in_row_q;
   logic [RW-1:0] row_q;
   logic [CW-1:0] cyc_q;
   logic [CW-1:0] last_cyc;
   logic          row_is_last;

   assign last_cyc    = CW'(SETTLE_CYC - 1) + CW'(dbc);
   assign last_stb    = in_row_q && (cyc_q >= last_cyc);
   assign ref_stb     = in_row_q && (cyc_q == CW'(SETTLE_CYC - 1));
   assign row_is_last = (row_q == RW'(N_ROWS - 1));
   assign pass_end    = last_stb && row_is_last;
   assign row_sel     = row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_row_q <= 1'b0;
         row_q    <= '0;
         cyc_q    <= '0;
      end else if (!en) begin
         in_row_q <= 1'b0;
         row_q    <= '0;
         cyc_q    <= '0;
      end else if (!in_row_q) begin
         if (cyc_q == CW'(PRE_CYC - 1)) begin
            in_row_q <= 1'b1;
            row_q    <= '0;
            cyc_q    <= '0;
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
      end else if (last_stb) begin
         cyc_q <= '0;
         if (row_is_last) begin
            in_row_q <= 1'b0;
            row_q    <= '0;
         end else begin
            row_q <= row_q + 1'b1;
         end
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      assign row_drive[r] = in_row_q && (row_q == RW'(r));
   end
endmodule

// File: rtl/kps_debounce.sv
module kps_debounce #(
   parameter int N_COLS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_stb,
   input  logic              last_stb,
   input  logic [N_COLS-1:0] col_in,
   output logic [N_COLS-1:0] accept
);
   logic [N_COLS-1:0] ref_q;
   logic [N_COLS-1:0] moved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= '0;
         moved_q <= '0;
      end else if (ref_stb) begin
         ref_q   <= col_in;
         moved_q <= '0;
      end else begin
         moved_q <= moved_q | (col_in ^ ref_q);
      end
   end

   always_comb begin
      accept = '0;
      if (last_stb) begin
         if (ref_stb) accept = col_in;
         else         accept = col_in & ~(moved_q | (col_in ^ ref_q));
      end
   end
endmodule

// File: rtl/kps_collect.sv
module kps_collect
   import kps_pkg::*;
#(
   parameter int N_COLS = 8,
   parameter int N_ENT  = 8,
   localparam int CNTW = $clog2(N_ENT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic [N_COLS-1:0]      accept,
   input  logic [ROW_FLD_W-1:0]   row_idx,
   input  logic                   row_masked,
   input  logic                   pass_end,
   output logic [N_ENT*ENT_W-1:0] snap,
   output logic [CNTW-1:0]        count,
   output logic                   done,
   output logic                   done_wake
);
   localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

   key_ent_t        build_q [N_ENT];
   key_ent_t        build_d [N_ENT];
   logic [CNTW-1:0] bcnt_q, bcnt_d;
   logic            wake_q, wake_d;
   key_ent_t        snap_q  [N_ENT];

   always_comb begin
      int k;
      build_d = build_q;
      k       = int'(bcnt_q);
      for (int c = 0; c < N_COLS; c++) begin
         if (accept[c] && k < N_ENT) begin
            build_d[k[IW-1:0]] = '{valid: 1'b1, row: row_idx, col: COL_FLD_W'(c)};
            k = k + 1;
         end
      end
      bcnt_d = CNTW'(k);
      wake_d = wake_q | ((|accept) & ~row_masked);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENT; i++) begin
            build_q[i] <= '0;
            snap_q[i]  <= '0;
         end
         bcnt_q    <= '0;
         count     <= '0;
         wake_q    <= 1'b0;
         done      <= 1'b0;
         done_wake <= 1'b0;
      end else if (!en) begin
         for (int i = 0; i < N_ENT; i++) begin
            build_q[i] <= '0;
            snap_q[i]  <= '0;
         end
         bcnt_q    <= '0;
         count     <= '0;
         wake_q    <= 1'b0;
         done      <= 1'b0;
         done_wake <= 1'b0;
      end else if (pass_end) begin
         snap_q    <= build_d;
         count     <= bcnt_d;
         done      <= 1'b1;
         done_wake <= wake_d;
         for (int i = 0; i < N_ENT; i++) build_q[i] <= '0;
         bcnt_q    <= '0;
         wake_q    <= 1'b0;
      end else begin
         build_q <= build_d;
         bcnt_q  <= bcnt_d;
         wake_q  <= wake_d;
         done    <= 1'b0;
      end
   end

   for (genvar e = 0; e < N_ENT; e++) begin : g_pack
      assign snap[e*ENT_W +: ENT_W] = snap_q[e];
   end
endmodule

// File: rtl/keypad_scan_ctrl.sv
module keypad_scan_ctrl
   import kps_pkg::*;
#(
   parameter int N_ROWS = 16,
   parameter int N_COLS = 8,
   parameter int N_ENT  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [N_ROWS-1:0] row_drive,
   input  logic [N_COLS-1:0] col_sense,
   output logic              irq
);
   localparam int RW   = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;
   localparam int CNTW = $clog2(N_ENT + 1);

   initial begin
      assert (N_ROWS >= 1 && N_ROWS <= MAX_ROWS) else $error("N_ROWS out of range");
      assert (N_COLS >= 1 && N_COLS <= MAX_COLS) else $error("N_COLS out of range");
      assert (N_ENT >= 1 && N_ENT <= MAX_ENT) else $error("N_ENT out of range");
      assert (CTL_DB_LSB + DB_W == CTL_THR_LSB) else $error("control fields overlap");
   end

   logic              en_q, kpie_q, cntie_q;
   logic [DB_W-1:0]   dbc_q;
   logic [THR_W-1:0]  thr_q;
   logic [N_ROWS-1:0] mask_q;
   logic              st_kp_q, st_cnt_q;

   logic [RW-1:0]          row_sel;
   logic                   ref_stb, last_stb, pass_end;
   logic [N_COLS-1:0]      accept;
   logic [N_ENT*ENT_W-1:0] snap;
   logic [CNTW-1:0]        count;
   logic                   done, done_wake;
   logic [3:0]             ent_num;
   logic [63:0]            ent_words;
   logic                   unused_wbits;

   assign unused_wbits = ^reg_wdata;

   kps_sequencer #(.N_ROWS(N_ROWS)) i_seq (
      .clk(clk), .rst_n(rst_n), .en(en_q), .dbc(dbc_q),
      .row_drive(row_drive), .row_sel(row_sel),
      .ref_stb(ref_stb), .last_stb(last_stb), .pass_end(pass_end)
   );

   kps_debounce #(.N_COLS(N_COLS)) i_deb (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .last_stb(last_stb),
      .col_in(col_sense), .accept(accept)
   );

   kps_collect #(.N_COLS(N_COLS), .N_ENT(N_ENT)) i_col (
      .clk(clk), .rst_n(rst_n), .en(en_q), .accept(accept),
      .row_idx(ROW_FLD_W'(row_sel)), .row_masked(mask_q[row_sel]),
      .pass_end(pass_end), .snap(snap), .count(count),
      .done(done), .done_wake(done_wake)
   );

   assign ent_num   = 4'(count);
   assign ent_words = 64'(snap);

   logic wr_ctrl, wr_stat, wr_mask;
   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign wr_stat = reg_wr && (reg_addr == A_STAT);
   assign wr_mask = reg_wr && (reg_addr == A_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         kpie_q  <= 1'b0;
         cntie_q <= 1'b0;
         dbc_q   <= '0;
         thr_q   <= '0;
         mask_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q    <= reg_wdata[CTL_EN];
            kpie_q  <= reg_wdata[CTL_KPIE];
            cntie_q <= reg_wdata[CTL_CNTIE];
            dbc_q   <= reg_wdata[CTL_DB_LSB +: DB_W];
            thr_q   <= reg_wdata[CTL_THR_LSB +: THR_W];
         end
         if (wr_mask) mask_q <= reg_wdata[N_ROWS-1:0];
      end
   end

   logic kp_set, cnt_set;
   assign kp_set  = done && done_wake && kpie_q;
   assign cnt_set = done && cntie_q && (ent_num >= thr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_kp_q  <= 1'b0;
         st_cnt_q <= 1'b0;
      end else if (!en_q) begin
         st_kp_q  <= 1'b0;
         st_cnt_q <= 1'b0;
      end else begin
         st_kp_q  <= kp_set  | (st_kp_q  & ~(wr_stat & reg_wdata[ST_KP]));
         st_cnt_q <= cnt_set | (st_cnt_q & ~(wr_stat & reg_wdata[ST_CNT]));
      end
   end

   assign irq = st_kp_q | st_cnt_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[CTL_EN]                 = en_q;
            reg_rdata[CTL_KPIE]               = kpie_q;
            reg_rdata[CTL_CNTIE]              = cntie_q;
            reg_rdata[CTL_DB_LSB +: DB_W]     = dbc_q;
            reg_rdata[CTL_THR_LSB +: THR_W]   = thr_q;
         end
         A_STAT: begin
            reg_rdata[ST_KP]            = st_kp_q;
            reg_rdata[ST_CNT]           = st_cnt_q;
            reg_rdata[ST_NUM_LSB +: 4]  = ent_num;
         end
         A_ENT_LO: reg_rdata = ent_words[31:0];
         A_ENT_HI: reg_rdata = ent_words[63:32];
         A_MASK:   reg_rdata = 32'(mask_q);
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/kps_checker.sv
module kps_checker #(
   parameter int N_ROWS = 16,
   parameter int N_ENT  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_ROWS-1:0] row_drive,
   input logic              irq,
   input logic              en,
   input logic              kp_ie,
   input logic              cnt_ie,
   input logic              st_kp,
   input logic              st_cnt,
   input logic [3:0]        ent_num
);
   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_drive)); // R2

   AST_ROW_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (row_drive != '0 && $past(row_drive) != '0 && row_drive != $past(row_drive))
      |-> (row_drive == ($past(row_drive) << 1))); // R2

   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      ent_num <= 4'(N_ENT)); // R5

   AST_KP_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_kp) |-> $past(kp_ie)); // R6

   AST_CNT_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_cnt) |-> $past(cnt_ie)); // R8

   AST_OFF_ROWS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (row_drive == '0)); // R10

   AST_OFF_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !irq); // R10
endmodule

bind keypad_scan_ctrl kps_checker #(.N_ROWS(N_ROWS), .N_ENT(N_ENT)) i_kps_checker (
   .clk(clk), .rst_n(rst_n), .row_drive(row_drive), .irq(irq),
   .en(en_q), .kp_ie(kpie_q), .cnt_ie(cntie_q),
   .st_kp(st_kp_q), .st_cnt(st_cnt_q), .ent_num(ent_num)
);

// File: tb/test_keypad_scan_ctrl.sv
module test_keypad_scan_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] row_drive;
   logic [7:0]  col_sense;
   logic        irq;

   logic [127:0] keys = '0;
   logic         bounce = 1'b0;
   logic [7:0]   tick = '0;
   int           errors = 0;
   int           checks = 0;

   always #4 clk = ~clk;
   always @(posedge clk) tick <= tick + 1'b1;

   always_comb begin
      col_sense = '0;
      for (int r = 0; r < 16; r++)
         if (row_drive[r]) col_sense = col_sense | keys[r*8 +: 8];
      if (bounce && row_drive[5]) col_sense[3] = tick[0];
   end

   keypad_scan_ctrl i_keypad_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .row_drive(row_drive),
      .col_sense(col_sense), .irq(irq)
   );

   typedef struct packed {
      logic [127:0] k;
      logic [31:0]  lo;
      logic [31:0]  hi;
      logic [3:0]   cnt;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{128'h0, 32'h0, 32'h0, 4'd0},
      '{128'h0020_0000, 32'h0000_0095, 32'h0, 4'd1},
      '{128'h80000000_00000000_00000000_00000001, 32'h0000_FF80, 32'h0, 4'd2},
      '{128'h00000000_00000100_00000000_06000000, 32'h00C8_9A99, 32'h0, 4'd3},
      '{128'h00000000_00000040_00000000_0000FF00, 32'h8B8A_8988, 32'h8F8E_8D8C, 4'd8}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_passes(input int dbc, input int n);
      repeat (n * (5 + 16 * (16 + dbc)) + 10) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=expired exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R1 reg", d, 32'h0);
      end
      check("R1 rows", 32'(row_drive), 32'h0);
      check("R1 irq", 32'(irq), 32'h0);

      // R2 lead-in and slot length with D=2
      wr(3'd0, 32'h0000_0021);
      n = 0;
      while (row_drive == '0 && n < 1000) begin n++; @(negedge clk); end
      check("R2 lead-in", 32'(n), 32'd5);
      check("R2 first row", 32'(row_drive), 32'h1);
      n = 0;
      while (row_drive == 16'h1 && n < 1000) begin n++; @(negedge clk); end
      check("R2 slot length", 32'(n), 32'd18);
      check("R2 next row", 32'(row_drive), 32'h2);

      // R4 R5 table of key maps
      for (int v = 0; v < 5; v++) begin
         keys = VECS[v].k;
         wait_passes(2, 3);
         rd(3'd2, d); check("R4 entries lo", d, VECS[v].lo);
         rd(3'd3, d); check("R5 entries hi", d, VECS[v].hi);
         rd(3'd1, d); check("R4 count", 32'(d[7:4]), 32'(VECS[v].cnt));
         check("R6 no int while disabled enables", 32'({d[2], d[0]}), 32'h0);
      end

      // R3 bouncing contact rejected, steady contact accepted, D=8
      keys = '0;
      wr(3'd0, 32'h0000_0081);
      bounce = 1'b1;
      wait_passes(8, 3);
      rd(3'd1, d); check("R3 bounce count", 32'(d[7:4]), 32'd0);
      bounce = 1'b0;
      keys[5*8+3] = 1'b1;
      wait_passes(8, 3);
      rd(3'd2, d); check("R3 steady entry", d, 32'h0000_00AB);

      // R6 keypress interrupt, R9 clear
      keys = '0;
      keys[2*8+5] = 1'b1;
      wr(3'd0, 32'h0000_0023);
      wait_passes(2, 3);
      rd(3'd1, d); check("R6 status", d, 32'h0000_0011);
      check("R9 irq high", 32'(irq), 32'h1);
      wr(3'd1, 32'h0);
      rd(3'd1, d); check("R9 zero write", 32'(d[0]), 32'h1);
      keys = '0;
      wait_passes(2, 3);
      wr(3'd1, 32'h1);
      rd(3'd1, d); check("R9 cleared", d, 32'h0);
      check("R9 irq low", 32'(irq), 32'h0);

      // R7 masked row
      wr(3'd4, 32'h0000_0004);
      keys[2*8+5] = 1'b1;
      wait_passes(2, 3);
      rd(3'd1, d); check("R7 masked status", d, 32'h0000_0010);
      check("R7 irq", 32'(irq), 32'h0);

      // R8 count threshold 2
      wr(3'd4, 32'h0);
      wr(3'd0, 32'h0000_8029);
      wait_passes(2, 3);
      rd(3'd1, d); check("R8 below", 32'(d[2]), 32'h0);
      check("R8 irq low", 32'(irq), 32'h0);
      keys[7*8+1] = 1'b1;
      wait_passes(2, 3);
      rd(3'd1, d); check("R8 reached", d, 32'h0000_0024);
      check("R8 irq high", 32'(irq), 32'h1);

      // R10 disable
      wr(3'd0, 32'h0);
      repeat (2) @(negedge clk);
      check("R10 rows", 32'(row_drive), 32'h0);
      check("R10 irq", 32'(irq), 32'h0);
      rd(3'd1, d); check("R10 status", d, 32'h0);
      rd(3'd2, d); check("R10 entries", d, 32'h0);
      wait_passes(2, 1);
      check("R10 rows stay idle", 32'(row_drive), 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule